// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Engine

This block keeps the transfer state of four DMA channels and sequences their byte transfers onto a memory bus. Each channel owns a 16-bit base and current address, a 16-bit base and current byte count, an 8-bit page register that supplies the upper address bits, and a mode byte. The CPU programs all of it through an 8-bit register port. A byte-pointer flip-flop steps through the low and high halves of each 16-bit register.

An external arbiter chooses which channel runs. It presents a channel number together with a grant strobe, and the engine then performs one byte transfer on that channel. A single-channel transfer drives a one-cycle memory read or write strobe at the channel's current address. The peripheral side of the bus is outside this block.

In memory-to-memory mode, channels 0 and 1 work as a pair. A byte is read from channel 0's address into an internal 8-bit holding register and then written to channel 1's address. At terminal count a channel either reloads from its base registers or masks itself. Address stepping never carries into the page bits, so a run wraps inside its 64 KiB page.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset all four channels are masked, every terminal-count bit is clear, the byte pointer selects the low byte, and neither memory strobe is active. A status read on select 8 returns terminal-count bits in [3:0] (bit n for channel n) and mask bits in [7:4] (bit 4+n for channel n), so the reset value is 0xF0.
- R2: Select 2n accesses channel n's address register and select 2n+1 accesses its count register. The first access moves the low byte and the next moves the high byte, and every read or write to selects 0..7 toggles the byte pointer. A write to select 11 clears the pointer to low. A write loads both the base and the current register, and a read returns the current value.
- R3: Select 8 is the mode write: data[1:0] is the channel, data[2]=1 steps the address down, data[3]=1 turns on auto-initialize, and data[4]=1 makes the transfer a memory write (0 makes it a memory read). Select 9 is the mask write: data[1:0] is the channel and data[2] is the mask value. While the engine is idle, a grant on an unmasked channel produces, in the next cycle, a one-cycle strobe of the mode's type with mem_addr_o = {page, current address}. A grant on a masked channel produces no strobe.
- R4: Each transfer moves the channel's current address one step in its programmed direction and decrements its current count by one.
- R5: tc_o is high, with tc_ch_o naming the channel, during the transfer that takes the current count from 1 to 0. A programmed count of 0 stands for 65536 bytes, so its first transfer raises no terminal count and leaves 0xFFFF in the count.
- R6: A terminal count sets that channel's status bit. A status read returns the bits and clears all of them afterwards. If a terminal count and a status read fall in the same cycle, the new bit survives.
- R7: At terminal count, a channel whose auto-initialize bit is clear sets its own mask bit.
- R8: At terminal count, a channel whose auto-initialize bit is set reloads its current address and count from its base registers and stays unmasked.
- R9: Selects 12..15 write the page registers of channels 0..3. The page forms mem_addr_o[23:16] and is never changed by stepping, so an address wraps from 0xFFFF to 0x0000 (or back the other way) inside the same page.
- R10: Select 10 data[0]=1 turns on memory-to-memory mode. A grant on channel 0, with channels 0 and 1 both unmasked, gives a read cycle at channel 0's address and then a write cycle at channel 1's address that carries the byte captured during the read. Both addresses step. Only channel 1's count decrements, and it alone drives terminal count. At the end each channel of the pair reloads or masks according to its own mode. In this mode a grant on channel 1 is ignored.
- R11: mem_rd_o and mem_wr_o are never high together, and each strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register port write strobe |
| reg_rd_i | input | 1 | Register port read strobe |
| reg_sel_i | input | 4 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (valid while reg_rd_i is high) |
| grant_i | input | 1 | Arbiter grant for one transfer |
| grant_ch_i | input | 2 | Granted channel |
| ch_mask_o | output | 4 | Per-channel mask state, for the arbiter |
| mem_addr_o | output | 24 | Memory address {page, address} |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Write data in memory-to-memory mode |
| mem_rdata_i | input | 8 | Memory read data |
| tc_o | output | 1 | Terminal-count pulse |
| tc_ch_o | output | 2 | Channel that reached terminal count |

## Verification
The bench builds the engine with its default parameters: four channels, a 16-bit address and an 8-bit page. With these values every channel, both step directions and every word count from 1 to 4 can be swept in turn. Every expected address comes from the programmed start value plus or minus the transfer index. Programming start addresses next to 0xFFFF and 0x0000 makes the in-page wrap reachable in a few cycles. A programmed count of zero exercises the 65536-byte case through its first transfer, so the full run is not needed.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_M_RD,
    ST_M_WR
  } seq_state_e;

  typedef struct packed {
    logic wr_type;    // 1: memory write strobe, 0: memory read strobe
    logic auto_init;
    logic dec;
  } ch_mode_t;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_xfer_pkg::*;
#(
  parameter int AW     = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        wdata_i,
  input  logic              hi_i,
  input  logic              addr_we_i,
  input  logic              cnt_we_i,
  input  logic              page_we_i,
  input  logic              mode_we_i,
  input  ch_mode_t          mode_i,
  input  logic              step_addr_i,
  input  logic              step_cnt_i,
  input  logic              reload_i,
  output logic [AW-1:0]     cur_addr_o,
  output logic [AW-1:0]     cur_cnt_o,
  output logic [PAGE_W-1:0] page_o,
  output ch_mode_t          mode_o
);

  localparam int HI_W = AW - 8;

  logic [AW-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
  logic [PAGE_W-1:0] page_q;
  ch_mode_t mode_q;

  function automatic logic [AW-1:0] put_byte(input logic [AW-1:0] old,
                                             input logic hi,
                                             input logic [7:0] d);
    logic [AW-1:0] r;
    r = old;
    if (hi) r[AW-1:8] = d[HI_W-1:0];
    else    r[7:0]    = d;
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      cur_addr_q  <= '0;
    end else if (addr_we_i) begin
      base_addr_q <= put_byte(base_addr_q, hi_i, wdata_i);
      cur_addr_q  <= put_byte(cur_addr_q, hi_i, wdata_i);
    end else if (reload_i) begin
      cur_addr_q <= base_addr_q;
    end else if (step_addr_i) begin
      // wraps inside the page: no carry out of AW bits
      cur_addr_q <= mode_q.dec ? cur_addr_q - AW'(1) : cur_addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_cnt_q <= '0;
      cur_cnt_q  <= '0;
    end else if (cnt_we_i) begin
      base_cnt_q <= put_byte(base_cnt_q, hi_i, wdata_i);
      cur_cnt_q  <= put_byte(cur_cnt_q, hi_i, wdata_i);
    end else if (reload_i) begin
      cur_cnt_q <= base_cnt_q;
    end else if (step_cnt_i) begin
      cur_cnt_q <= cur_cnt_q - AW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      mode_q <= '0;
    end else begin
      if (page_we_i) page_q <= wdata_i[PAGE_W-1:0];
      if (mode_we_i) mode_q <= mode_i;
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;
  assign page_o     = page_q;
  assign mode_o     = mode_q;

endmodule

// File: rtl/dma_stat.sv
module dma_stat #(
  parameter int NUM_CH = 4,
  parameter int CHW    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] tc_set_i,
  input  logic              stat_rd_i,
  input  logic              mask_we_i,
  input  logic [CHW-1:0]    mask_ch_i,
  input  logic              mask_val_i,
  input  logic [NUM_CH-1:0] mask_auto_i,
  input  logic              ptr_clr_i,
  input  logic              ptr_tog_i,
  output logic [NUM_CH-1:0] tc_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic              ptr_o
);

  logic [NUM_CH-1:0] tc_q, mask_q, mask_n;
  logic ptr_q;

  always_comb begin
    mask_n = mask_q;
    if (mask_we_i) mask_n[mask_ch_i] = mask_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q   <= '0;
      mask_q <= '1;
      ptr_q  <= 1'b0;
    end else begin
      // a fresh terminal count outlives a same-cycle status read
      tc_q   <= (stat_rd_i ? '0 : tc_q) | tc_set_i;
      mask_q <= mask_n | mask_auto_i;
      if (ptr_clr_i)      ptr_q <= 1'b0;
      else if (ptr_tog_i) ptr_q <= ~ptr_q;
    end
  end

  assign tc_o   = tc_q;
  assign mask_o = mask_q;
  assign ptr_o  = ptr_q;

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_xfer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CHW    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_i,
  input  logic [CHW-1:0]    grant_ch_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              m2m_i,
  input  logic [7:0]        rdata_i,
  output seq_state_e        state_o,
  output logic [CHW-1:0]    act_ch_o,
  output logic [7:0]        hold_o
);

  seq_state_e state_q;
  logic [CHW-1:0] act_q;
  logic [7:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      hold_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (grant_i && !mask_i[grant_ch_i]) begin
            if (m2m_i && grant_ch_i == CHW'(0)) begin
              if (!mask_i[1]) begin
                state_q <= ST_M_RD;
                act_q   <= '0;
              end
            end else if (!(m2m_i && grant_ch_i == CHW'(1))) begin
              state_q <= ST_XFER;
              act_q   <= grant_ch_i;
            end
          end
        end
        ST_M_RD: begin
          hold_q  <= rdata_i;
          state_q <= ST_M_WR;
        end
        ST_M_WR: state_q <= ST_IDLE;
        ST_XFER: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign act_ch_o = act_q;
  assign hold_o   = hold_q;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  parameter int PAGE_W = 8,
  localparam int CHW   = $clog2(NUM_CH),
  localparam int MW    = PAGE_W + AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [3:0]        reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              grant_i,
  input  logic [CHW-1:0]    grant_ch_i,
  output logic [NUM_CH-1:0] ch_mask_o,
  output logic [MW-1:0]     mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              tc_o,
  output logic [CHW-1:0]    tc_ch_o
);

  logic [AW-1:0]     cur_addr [NUM_CH];
  logic [AW-1:0]     cur_cnt  [NUM_CH];
  logic [PAGE_W-1:0] page     [NUM_CH];
  ch_mode_t          mode     [NUM_CH];

  logic [NUM_CH-1:0] addr_we, cnt_we, page_we, mode_we;
  logic [NUM_CH-1:0] step_addr, step_cnt, end_ev, reload, tc_set, mask_auto;
  logic [NUM_CH-1:0] tc_q, mask_q;
  logic              ptr_q, m2m_q;
  seq_state_e        state_q;
  logic [CHW-1:0]    act_ch;
  logic [7:0]        hold_q;
  logic [CHW-1:0]    sel_ch;
  logic [AW-1:0]     rd_val;
  ch_mode_t          mode_wd;
  logic              ptr_tog, ptr_clr, stat_rd, mask_we;

  // register port decode
  assign sel_ch  = reg_sel_i[CHW:1];
  assign mode_wd = '{wr_type: reg_wdata_i[4], auto_init: reg_wdata_i[3], dec: reg_wdata_i[2]};
  assign ptr_tog = (reg_wr_i | reg_rd_i) & ~reg_sel_i[3];
  assign ptr_clr = reg_wr_i & (reg_sel_i == 4'hB);
  assign stat_rd = reg_rd_i & (reg_sel_i == 4'h8);
  assign mask_we = reg_wr_i & (reg_sel_i == 4'h9);

  always_comb begin
    addr_we = '0;
    cnt_we  = '0;
    page_we = '0;
    mode_we = '0;
    if (reg_wr_i) begin
      if (!reg_sel_i[3]) begin
        if (reg_sel_i[0]) cnt_we[sel_ch]  = 1'b1;
        else              addr_we[sel_ch] = 1'b1;
      end else if (reg_sel_i[3:2] == 2'b11) begin
        page_we[reg_sel_i[CHW-1:0]] = 1'b1;
      end else if (reg_sel_i == 4'h8) begin
        mode_we[reg_wdata_i[CHW-1:0]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              m2m_q <= 1'b0;
    else if (reg_wr_i && reg_sel_i == 4'hA)   m2m_q <= reg_wdata_i[0];
  end

  always_comb begin
    reg_rdata_o = '0;
    rd_val      = reg_sel_i[0] ? cur_cnt[sel_ch] : cur_addr[sel_ch];
    if (reg_rd_i) begin
      if (!reg_sel_i[3])            reg_rdata_o = ptr_q ? 8'(rd_val >> 8) : rd_val[7:0];
      else if (reg_sel_i == 4'h8)   reg_rdata_o = 8'({mask_q, tc_q});
    end
  end

  // memory side
  always_comb begin
    mem_addr_o  = '0;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_wdata_o = '0;
    tc_o        = 1'b0;
    tc_ch_o     = act_ch;
    unique case (state_q)
      ST_XFER: begin
        mem_addr_o = {page[act_ch], cur_addr[act_ch]};
        mem_rd_o   = ~mode[act_ch].wr_type;
        mem_wr_o   = mode[act_ch].wr_type;
        tc_o       = (cur_cnt[act_ch] == AW'(1));
      end
      ST_M_RD: begin
        mem_addr_o = {page[0], cur_addr[0]};
        mem_rd_o   = 1'b1;
      end
      ST_M_WR: begin
        mem_addr_o  = {page[1], cur_addr[1]};
        mem_wr_o    = 1'b1;
        mem_wdata_o = hold_q;
        tc_o        = (cur_cnt[1] == AW'(1));
        tc_ch_o     = CHW'(1);
      end
      default: ;
    endcase
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam bit IN_PAIR = (c < 2);
    localparam bit CNT_CH  = (c == 1);
    logic is_act;

    assign is_act       = (state_q == ST_XFER) && (act_ch == CHW'(c));
    assign step_addr[c] = is_act | ((state_q == ST_M_WR) & IN_PAIR);
    assign step_cnt[c]  = is_act | ((state_q == ST_M_WR) & CNT_CH);
    assign end_ev[c]    = tc_o & step_addr[c];
    assign reload[c]    = end_ev[c] & mode[c].auto_init;
    assign mask_auto[c] = end_ev[c] & ~mode[c].auto_init;
    assign tc_set[c]    = tc_o & (tc_ch_o == CHW'(c));

    dma_chan_regs #(.AW(AW), .PAGE_W(PAGE_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wdata_i     (reg_wdata_i),
      .hi_i        (ptr_q),
      .addr_we_i   (addr_we[c]),
      .cnt_we_i    (cnt_we[c]),
      .page_we_i   (page_we[c]),
      .mode_we_i   (mode_we[c]),
      .mode_i      (mode_wd),
      .step_addr_i (step_addr[c]),
      .step_cnt_i  (step_cnt[c]),
      .reload_i    (reload[c]),
      .cur_addr_o  (cur_addr[c]),
      .cur_cnt_o   (cur_cnt[c]),
      .page_o      (page[c]),
      .mode_o      (mode[c])
    );
  end

  dma_stat #(.NUM_CH(NUM_CH), .CHW(CHW)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tc_set_i    (tc_set),
    .stat_rd_i   (stat_rd),
    .mask_we_i   (mask_we),
    .mask_ch_i   (reg_wdata_i[CHW-1:0]),
    .mask_val_i  (reg_wdata_i[2]),
    .mask_auto_i (mask_auto),
    .ptr_clr_i   (ptr_clr),
    .ptr_tog_i   (ptr_tog),
    .tc_o        (tc_q),
    .mask_o      (mask_q),
    .ptr_o       (ptr_q)
  );

  dma_seq #(.NUM_CH(NUM_CH), .CHW(CHW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_i    (grant_i),
    .grant_ch_i (grant_ch_i),
    .mask_i     (mask_q),
    .m2m_i      (m2m_q),
    .rdata_i    (mem_rdata_i),
    .state_o    (state_q),
    .act_ch_o   (act_ch),
    .hold_o     (hold_q)
  );

  assign ch_mask_o = mask_q;

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk
  import dma_xfer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CHW    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              grant_i,
  input logic [CHW-1:0]    grant_ch_i,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [7:0]        mem_wdata_o,
  input logic [7:0]        mem_rdata_i,
  input logic              tc_o,
  input logic [CHW-1:0]    tc_ch_o,
  input seq_state_e        state_q,
  input logic [NUM_CH-1:0] tc_q,
  input logic [NUM_CH-1:0] mask_q
);

  // R11
  rw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  // R11
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> !(mem_rd_o || mem_wr_o));

  // R5
  tc_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (mem_rd_o || mem_wr_o));

  // R6
  tc_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> tc_q[$past(tc_ch_o)]);

  // R3
  masked_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && grant_i && mask_q[grant_ch_i]) |=> (state_q == ST_IDLE));

  // R10
  m2m_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_M_RD) |=> (mem_wr_o && mem_wdata_o == $past(mem_rdata_i)));

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.NUM_CH(NUM_CH), .CHW(CHW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .grant_i     (grant_i),
  .grant_ch_i  (grant_ch_i),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i),
  .tc_o        (tc_o),
  .tc_ch_o     (tc_ch_o),
  .state_q     (state_q),
  .tc_q        (tc_q),
  .mask_q      (mask_q)
);

// File: tb/dma_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        grant = 1'b0;
  logic [1:0]  grant_ch = '0;
  logic [3:0]  ch_mask;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr, tc;
  logic [7:0]  mem_wdata, mem_rdata = '0;
  logic [1:0]  tc_ch;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dma_xfer_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .grant_i(grant), .grant_ch_i(grant_ch), .ch_mask_o(ch_mask),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .tc_o(tc), .tc_ch_o(tc_ch)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d);
    reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic prog16(input logic [3:0] s, input logic [15:0] v);
    wr(4'hB, 8'h00);
    wr(s, v[7:0]);
    wr(s, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] s, output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(4'hB, 8'h00);
    rd(s, lo);
    rd(s, hi);
    v = {hi, lo};
  endtask

  task automatic set_mode(input logic [1:0] ch, input logic dec, input logic auto_i, input logic wt);
    wr(4'h8, {3'b000, wt, auto_i, dec, ch});
  endtask

  task automatic set_mask(input logic [1:0] ch, input logic v);
    wr(4'h9, {5'b00000, v, ch});
  endtask

  task automatic one_xfer(input logic [1:0] ch, input logic [23:0] ea, input logic wt, input logic etc);
    grant = 1'b1; grant_ch = ch;
    @(negedge clk);
    grant = 1'b0;
    chk("R3/R9 address", 32'(mem_addr), 32'(ea));
    chk("R11/R3 strobe type", 32'({mem_rd, mem_wr}), wt ? 32'h1 : 32'h2);
    chk("R5 tc pulse", 32'(tc), 32'(etc));
    if (etc) chk("R5 tc channel", 32'(tc_ch), 32'(ch));
    @(negedge clk);
  endtask

  task automatic no_xfer(input logic [1:0] ch, input string tag);
    grant = 1'b1; grant_ch = ch;
    @(negedge clk);
    grant = 1'b0;
    chk(tag, 32'({mem_rd, mem_wr}), 32'h0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  st;
    logic [15:0] v, a0, ea;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h8, st);
    chk("R1 status after reset", 32'(st), 32'hF0);
    chk("R1 strobes idle", 32'({mem_rd, mem_wr}), 32'h0);
    chk("R1 mask port", 32'(ch_mask), 32'hF);
    rd(4'h0, st);
    chk("R1 pointer low after reset", 32'(st), 32'h00);

    // R2 byte pointer
    prog16(4'h0, 16'h1234);
    rd16(4'h0, v);
    chk("R2 16-bit readback", 32'(v), 32'h1234);
    wr(4'hB, 8'h00);
    wr(4'h0, 8'h56);
    wr(4'hB, 8'h00);
    rd(4'h0, st);
    chk("R2 low byte rewritten", 32'(st), 32'h56);
    rd(4'h0, st);
    chk("R2 pointer toggled to high", 32'(st), 32'h12);

    // sweep: channel x direction x count
    for (int ch = 0; ch < 4; ch++) begin
      for (int d = 0; d < 2; d++) begin
        for (int n = 1; n <= 4; n++) begin
          a0 = 16'(16'h1000 * ch + 16'h0080);
          wr(4'(12 + ch), 8'(8'h10 + ch));
          prog16(4'(2 * ch), a0);
          prog16(4'(2 * ch + 1), 16'(n));
          set_mode(2'(ch), d[0], 1'b0, ch[0]);
          set_mask(2'(ch), 1'b0);
          for (int i = 0; i < n; i++) begin
            ea = d[0] ? 16'(a0 - 16'(i)) : 16'(a0 + 16'(i));
            one_xfer(2'(ch), {8'(8'h10 + ch), ea}, ch[0], (i == n - 1));
          end
          rd(4'h8, st);
          chk("R6 tc bit set", 32'(st[ch]), 32'h1);
          chk("R7 self-mask", 32'(st[4 + ch]), 32'h1);
          rd(4'h8, st);
          chk("R6 tc cleared by read", 32'(st[ch]), 32'h0);
          no_xfer(2'(ch), "R3 masked grant ignored");
          rd16(4'(2 * ch), v);
          chk("R4 address stepped", 32'(v), d[0] ? 32'(16'(a0 - 16'(n))) : 32'(16'(a0 + 16'(n))));
          rd16(4'(2 * ch + 1), v);
          chk("R4 count exhausted", 32'(v), 32'h0);
        end
      end
    end

    // R5 count zero means 65536
    wr(4'hD, 8'h33);
    prog16(4'h2, 16'h4000);
    prog16(4'h3, 16'h0000);
    set_mode(2'd1, 1'b0, 1'b0, 1'b0);
    set_mask(2'd1, 1'b0);
    one_xfer(2'd1, 24'h334000, 1'b0, 1'b0);
    rd16(4'h3, v);
    chk("R5 zero count wraps", 32'(v), 32'hFFFF);
    set_mask(2'd1, 1'b1);

    // R8 auto-initialize
    wr(4'hE, 8'h22);
    prog16(4'h4, 16'h0500);
    prog16(4'h5, 16'h0003);
    set_mode(2'd2, 1'b0, 1'b1, 1'b1);
    set_mask(2'd2, 1'b0);
    for (int i = 0; i < 3; i++) one_xfer(2'd2, 24'h220500 + 24'(i), 1'b1, (i == 2));
    rd(4'h8, st);
    chk("R8 stays unmasked", 32'(st[6]), 32'h0);
    chk("R6 tc bit on auto channel", 32'(st[2]), 32'h1);
    rd16(4'h4, v);
    chk("R8 address reloaded", 32'(v), 32'h0500);
    rd16(4'h5, v);
    chk("R8 count reloaded", 32'(v), 32'h0003);
    one_xfer(2'd2, 24'h220500, 1'b1, 1'b0);
    set_mask(2'd2, 1'b1);

    // R9 page wrap both directions
    wr(4'hF, 8'h7A);
    prog16(4'h6, 16'hFFFE);
    prog16(4'h7, 16'h0004);
    set_mode(2'd3, 1'b0, 1'b0, 1'b0);
    set_mask(2'd3, 1'b0);
    for (int i = 0; i < 4; i++) one_xfer(2'd3, {8'h7A, 16'(16'hFFFE + 16'(i))}, 1'b0, (i == 3));
    prog16(4'h6, 16'h0001);
    prog16(4'h7, 16'h0003);
    set_mode(2'd3, 1'b1, 1'b0, 1'b0);
    set_mask(2'd3, 1'b0);
    for (int i = 0; i < 3; i++) one_xfer(2'd3, {8'h7A, 16'(16'h0001 - 16'(i))}, 1'b0, (i == 2));
    rd16(4'h6, v);
    chk("R9 wrapped down in page", 32'(v), 32'hFFFE);

    // R10 memory to memory
    wr(4'hC, 8'h01);
    wr(4'hD, 8'h02);
    prog16(4'h0, 16'h0100);
    prog16(4'h1, 16'h0010);
    prog16(4'h2, 16'h0200);
    prog16(4'h3, 16'h0003);
    set_mode(2'd0, 1'b0, 1'b0, 1'b0);
    set_mode(2'd1, 1'b0, 1'b0, 1'b0);
    set_mask(2'd0, 1'b0);
    set_mask(2'd1, 1'b0);
    wr(4'hA, 8'h01);
    rd(4'h8, st);
    no_xfer(2'd1, "R10 channel 1 grant ignored");
    for (int i = 0; i < 3; i++) begin
      grant = 1'b1; grant_ch = 2'd0;
      @(negedge clk);
      grant = 1'b0;
      chk("R10 read strobe", 32'({mem_rd, mem_wr}), 32'h2);
      chk("R10 source address", 32'(mem_addr), 32'h010100 + 32'(i));
      mem_rdata = 8'(8'hA0 + i);
      @(negedge clk);
      mem_rdata = 8'h00;
      chk("R10 write strobe", 32'({mem_rd, mem_wr}), 32'h1);
      chk("R10 destination address", 32'(mem_addr), 32'h020200 + 32'(i));
      chk("R10 staged byte", 32'(mem_wdata), 32'hA0 + 32'(i));
      chk("R10 tc from channel 1", 32'({tc, tc_ch}), (i == 2) ? 32'h5 : 32'(tc_ch));
      @(negedge clk);
    end
    rd(4'h8, st);
    chk("R10 status after pair", 32'(st[5:0]), 32'h32);
    rd16(4'h1, v);
    chk("R10 channel 0 count untouched", 32'(v), 32'h0010);
    rd16(4'h0, v);
    chk("R10 source stepped", 32'(v), 32'h0103);
    wr(4'hA, 8'h00);

    // R1 reset again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h8, st);
    chk("R1 status after second reset", 32'(st), 32'hF0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule